// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers the four interrupt sources of a small 8-bit microcontroller core into one request line for the core. The four sources are:

- an external pin, with a selectable edge;
- an 8-bit timer rolling over;
- any change on a 4-bit slice of a port;
- a pulse from the nonvolatile memory engine when a write is done.

Each source owns a flag and an enable. One global enable gates the request to the core. The flags sit next to the enables in one 8-bit control/status register. The write-done flag is the exception: it lives in a separate memory-control register. The core reads and writes both registers over a simple one-cycle register bus.

The core drives three inputs:

- an acknowledge when it takes the interrupt, which clears the global enable in hardware;
- a return strobe, which sets the global enable again;
- a sleep level.

While the core sleeps, an enabled flag raises a wake-up output whatever the global enable holds. The vector output always carries the fixed service address. The pin, timer and port inputs are sampled synchronously. The block compares each with its previous sample to find edges, changes and rollovers.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and both irq_req and wake_req are 0.
- R2: The pin flag sets on a rising edge of ext_pin when ext_edge_rise is 1, and on a falling edge when it is 0. The pin flag is control bit 1. An edge of the other polarity leaves the flag unchanged.
- R3: The timer flag sets only when tmr_count moves from 0xFF to 0x00 between two consecutive clock edges. The timer flag is control bit 2. Other transitions, such as 0x7F to 0x80, leave it unchanged.
- R4: The port-change flag sets when any bit of port_hi differs from its value at the previous clock edge. The port-change flag is control bit 0.
- R5: A one-cycle nvm_wr_done pulse sets the write-done flag. This flag is bit 4 of the memory-control register, selected with reg_sel=1. Every other bit of that register reads 0.
- R6: Every flag sets on its event whatever its own enable and the global enable hold.
- R7: irq_req is 1 exactly when the global enable is 1 and at least one source has both its flag and its enable set. The control bits are: 7 global enable; 6 write-done enable; 5 timer enable; 4 pin enable; 3 port enable. irq_vector is always 0x004.
- R8: irq_ack clears the global enable at the next clock edge. It takes precedence over an irq_ret or a register write in the same cycle.
- R9: irq_ret, without irq_ack, sets the global enable. A flag that is still set and enabled then raises irq_req again at once.
- R10: A flag event and a register write that clears that same flag in one cycle leave the flag set.
- R11: wake_req is 1 exactly when core_sleep is 1 and at least one source has its flag and enable set, independent of the global enable.
- R12: During the first clock edge after reset, the pin, timer and port inputs are only sampled, so that edge sets none of their flags.
- R13: A write with reg_we=1 loads the register selected by reg_sel (0 = control, 1 = memory-control). reg_rdata shows the selected register combinationally. A write to the memory-control register changes only bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, synchronous |
| ext_edge_rise | input | 1 | 1 = rising edge triggers, 0 = falling edge triggers |
| tmr_count | input | 8 | Current timer count value |
| port_hi | input | 4 | Watched port bits |
| nvm_wr_done | input | 1 | One-cycle pulse when a nonvolatile write finishes |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = memory-control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| irq_ack | input | 1 | Core accepts the interrupt |
| irq_ret | input | 1 | Core returns from the service routine |
| core_sleep | input | 1 | Core is in sleep mode |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 12 | Service address, fixed at 0x004 |
| wake_req | output | 1 | Wake-up request while asleep |

## Verification
Two pairs of events can land in the same cycle:

- A hardware flag event can coincide with a software write to the control register that clears the same flag.
- The acknowledge can coincide with the return strobe or a write of the global enable.

Directed steps force both collisions on purpose. A random phase then overlaps sparse writes, acknowledges, returns and source events many times. Every cycle, a bench model applies "set beats clear" and "acknowledge beats return beats write". Its register image, request and wake-up are compared with the outputs.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int REG_W      = 8;

  // control register bit positions (software decodes these)
  localparam int GEN_BIT    = 7;
  localparam int NV_EN_BIT  = 6;
  localparam int TM_EN_BIT  = 5;
  localparam int PX_EN_BIT  = 4;
  localparam int PC_EN_BIT  = 3;
  localparam int TM_FL_BIT  = 2;
  localparam int PX_FL_BIT  = 1;
  localparam int PC_FL_BIT  = 0;

  // memory-control register: write-done flag position
  localparam int NV_FL_BIT  = 4;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_MEMCTL = 1'b1
  } reg_sel_e;

  // one bit per source: write-done, timer, pin, port
  typedef struct packed {
    logic nv;
    logic tm;
    logic px;
    logic pc;
  } src_vec_t;

  function automatic logic pick_edge(input logic prev, input logic cur,
                                     input logic rising);
    return rising ? (~prev & cur) : (prev & ~cur);
  endfunction

  function automatic logic merge_flag(input logic old_v, input logic wr,
                                      input logic wr_bit, input logic set_ev);
    // a hardware set wins over a software clear
    return set_ev | (wr ? wr_bit : old_v);
  endfunction

  function automatic src_vec_t flags_of(input logic [REG_W-1:0] ctrl,
                                        input logic nv_flag);
    src_vec_t f;
    f.nv = nv_flag;
    f.tm = ctrl[TM_FL_BIT];
    f.px = ctrl[PX_FL_BIT];
    f.pc = ctrl[PC_FL_BIT];
    return f;
  endfunction

  function automatic src_vec_t enables_of(input logic [REG_W-1:0] ctrl);
    src_vec_t e;
    e.nv = ctrl[NV_EN_BIT];
    e.tm = ctrl[TM_EN_BIT];
    e.px = ctrl[PX_EN_BIT];
    e.pc = ctrl[PC_EN_BIT];
    return e;
  endfunction

  function automatic logic any_active(input src_vec_t fl, input src_vec_t en);
    return |(fl & en);
  endfunction

endpackage

// File: rtl/irq_event_detect.sv
module irq_event_detect
  import irq_ctrl_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              edge_rise,
  input  logic [TMR_W-1:0]  tmr_count,
  input  logic [PORT_W-1:0] port_in,
  input  logic              nvm_done,
  output logic              armed,
  output logic              ext_hit,
  output logic              tmr_hit,
  output logic              port_hit,
  output logic              nv_hit
);

  localparam logic [TMR_W-1:0] TMR_TOP = {TMR_W{1'b1}};

  logic              armed_q;
  logic              pin_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] bit_diff;

  function automatic logic rolled_over(input logic [TMR_W-1:0] prev,
                                       input logic [TMR_W-1:0] cur);
    return (prev == TMR_TOP) && (cur == '0);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pin_q   <= 1'b0;
      tmr_q   <= '0;
      port_q  <= '0;
    end else begin
      armed_q <= 1'b1;
      pin_q   <= ext_pin;
      tmr_q   <= tmr_count;
      port_q  <= port_in;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_port_cmp
    assign bit_diff[i] = port_in[i] ^ port_q[i];
  end

  assign armed    = armed_q;
  assign ext_hit  = armed_q & pick_edge(pin_q, ext_pin, edge_rise);
  assign tmr_hit  = armed_q & rolled_over(tmr_q, tmr_count);
  assign port_hit = armed_q & (|bit_diff);
  assign nv_hit   = nvm_done;

endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  src_vec_t         hit,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic [REG_W-1:0] ctrl_q,
  output logic             nv_flag_q,
  output logic [REG_W-1:0] reg_rdata
);

  logic             wr_ctrl;
  logic             wr_mem;
  logic [REG_W-1:0] ctrl_d;
  logic             nv_flag_d;

  assign wr_ctrl = reg_we & (reg_sel == SEL_CTRL);
  assign wr_mem  = reg_we & (reg_sel == SEL_MEMCTL);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d[NV_EN_BIT] = reg_wdata[NV_EN_BIT];
      ctrl_d[TM_EN_BIT] = reg_wdata[TM_EN_BIT];
      ctrl_d[PX_EN_BIT] = reg_wdata[PX_EN_BIT];
      ctrl_d[PC_EN_BIT] = reg_wdata[PC_EN_BIT];
    end
    ctrl_d[TM_FL_BIT] = merge_flag(ctrl_q[TM_FL_BIT], wr_ctrl,
                                   reg_wdata[TM_FL_BIT], hit.tm);
    ctrl_d[PX_FL_BIT] = merge_flag(ctrl_q[PX_FL_BIT], wr_ctrl,
                                   reg_wdata[PX_FL_BIT], hit.px);
    ctrl_d[PC_FL_BIT] = merge_flag(ctrl_q[PC_FL_BIT], wr_ctrl,
                                   reg_wdata[PC_FL_BIT], hit.pc);
    // acknowledge beats return, return beats software
    if (irq_ack)       ctrl_d[GEN_BIT] = 1'b0;
    else if (irq_ret)  ctrl_d[GEN_BIT] = 1'b1;
    else if (wr_ctrl)  ctrl_d[GEN_BIT] = reg_wdata[GEN_BIT];
    nv_flag_d = merge_flag(nv_flag_q, wr_mem, reg_wdata[NV_FL_BIT], hit.nv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      nv_flag_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      nv_flag_q <= nv_flag_d;
    end
  end

  always_comb begin
    if (reg_sel == SEL_CTRL) begin
      reg_rdata = ctrl_q;
    end else begin
      reg_rdata            = '0;
      reg_rdata[NV_FL_BIT] = nv_flag_q;
    end
  end

endmodule

// File: rtl/irq_req_logic.sv
module irq_req_logic
  import irq_ctrl_pkg::*;
#(
  parameter int               VEC_W  = 12,
  parameter logic [VEC_W-1:0] VECTOR = 12'h004
) (
  input  logic [REG_W-1:0] ctrl,
  input  logic             nv_flag,
  input  logic             core_sleep,
  output logic             pending,
  output logic             irq_req,
  output logic             wake_req,
  output logic [VEC_W-1:0] irq_vector
);

  src_vec_t flags;
  src_vec_t enables;

  assign flags      = flags_of(ctrl, nv_flag);
  assign enables    = enables_of(ctrl);
  assign pending    = any_active(flags, enables);
  assign irq_req    = ctrl[GEN_BIT] & pending;
  assign wake_req   = core_sleep & pending;
  assign irq_vector = VECTOR;

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int               TMR_W  = 8,
  parameter int               PORT_W = 4,
  parameter int               VEC_W  = 12,
  parameter logic [VEC_W-1:0] VECTOR = 12'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic              ext_edge_rise,
  input  logic [TMR_W-1:0]  tmr_count,
  input  logic [PORT_W-1:0] port_hi,
  input  logic              nvm_wr_done,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              irq_ack,
  input  logic              irq_ret,
  input  logic              core_sleep,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              wake_req
);

  logic             armed;
  logic             ext_hit;
  logic             tmr_hit;
  logic             port_hit;
  logic             nv_hit;
  src_vec_t         hit;
  logic [REG_W-1:0] ctrl_q;
  logic             nv_flag_q;
  logic             pending;

  irq_event_detect #(
    .TMR_W  (TMR_W),
    .PORT_W (PORT_W)
  ) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_pin   (ext_pin),
    .edge_rise (ext_edge_rise),
    .tmr_count (tmr_count),
    .port_in   (port_hi),
    .nvm_done  (nvm_wr_done),
    .armed     (armed),
    .ext_hit   (ext_hit),
    .tmr_hit   (tmr_hit),
    .port_hit  (port_hit),
    .nv_hit    (nv_hit)
  );

  always_comb begin
    hit.nv = nv_hit;
    hit.tm = tmr_hit;
    hit.px = ext_hit;
    hit.pc = port_hit;
  end

  irq_ctrl_reg u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit       (hit),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .irq_ack   (irq_ack),
    .irq_ret   (irq_ret),
    .ctrl_q    (ctrl_q),
    .nv_flag_q (nv_flag_q),
    .reg_rdata (reg_rdata)
  );

  irq_req_logic #(
    .VEC_W  (VEC_W),
    .VECTOR (VECTOR)
  ) u_req (
    .ctrl       (ctrl_q),
    .nv_flag    (nv_flag_q),
    .core_sleep (core_sleep),
    .pending    (pending),
    .irq_req    (irq_req),
    .wake_req   (wake_req),
    .irq_vector (irq_vector)
  );

endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_ack,
  input logic       irq_ret,
  input logic       reg_we,
  input logic       core_sleep,
  input logic [7:0] ctrl,
  input logic       nv_flag,
  input logic       armed,
  input logic       ext_hit,
  input logic       tmr_hit,
  input logic       port_hit,
  input logic       nv_hit,
  input logic       irq_req,
  input logic       wake_req
);

  // R8
  ack_clears_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !ctrl[7]);

  // R9
  ret_sets_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && !irq_ack) |=> ctrl[7]);

  // R2
  pin_flag_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> ctrl[1]);

  // R3
  tmr_flag_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit |=> ctrl[2]);

  // R4
  port_flag_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |=> ctrl[0]);

  // R5
  nv_flag_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_hit |=> nv_flag);

  // R7
  req_needs_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ctrl[7]);

  // R11
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_sleep |-> !wake_req);

  // R12
  first_edge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !reg_we) |=> (ctrl[2:0] == 3'b000));

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_ack    (irq_ack),
  .irq_ret    (irq_ret),
  .reg_we     (reg_we),
  .core_sleep (core_sleep),
  .ctrl       (ctrl_q),
  .nv_flag    (nv_flag_q),
  .armed      (armed),
  .ext_hit    (ext_hit),
  .tmr_hit    (tmr_hit),
  .port_hit   (port_hit),
  .nv_hit     (nv_hit),
  .irq_req    (irq_req),
  .wake_req   (wake_req)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;

  localparam int CLK_PERIOD  = 10;
  localparam int RAND_CYCLES = 3000;
  localparam int WATCHDOG    = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0;
  logic        ext_edge_rise = 1'b0;
  logic [7:0]  tmr_count = 8'h00;
  logic [3:0]  port_hi = 4'h0;
  logic        nvm_wr_done = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        irq_ack = 1'b0;
  logic        irq_ret = 1'b0;
  logic        core_sleep = 1'b0;
  logic        irq_req;
  logic [11:0] irq_vector;
  logic        wake_req;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench model state
  logic [7:0] m_ctrl;
  logic       m_nv;
  logic       m_armed;
  logic       p_pin;
  logic [7:0] p_tmr;
  logic [3:0] p_port;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_flag_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ext_pin       (ext_pin),
    .ext_edge_rise (ext_edge_rise),
    .tmr_count     (tmr_count),
    .port_hi       (port_hi),
    .nvm_wr_done   (nvm_wr_done),
    .reg_we        (reg_we),
    .reg_sel       (reg_sel),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_ack       (irq_ack),
    .irq_ret       (irq_ret),
    .core_sleep    (core_sleep),
    .irq_req       (irq_req),
    .irq_vector    (irq_vector),
    .wake_req      (wake_req)
  );

  // enables in bits 6:3 line up with sources {write-done, timer, pin, port}
  function automatic logic exp_pending();
    return |(m_ctrl[6:3] & {m_nv, m_ctrl[2:0]});
  endfunction

  function automatic logic [7:0] exp_rdata();
    return reg_sel ? {3'b000, m_nv, 4'b0000} : m_ctrl;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R13/R1 reg_rdata", 32'(reg_rdata), 32'(exp_rdata()));
    chk("R7 irq_req", 32'(irq_req), 32'(m_ctrl[7] & exp_pending()));
    chk("R11 wake_req", 32'(wake_req), 32'(core_sleep & exp_pending()));
    chk("R7 irq_vector", 32'(irq_vector), 32'h004);
  endtask

  // model one clock edge from the driven inputs, advance, check, drop pulses
  task automatic tick();
    logic hx, ht, hp, wc, wm;
    logic [7:0] nxt;
    hx = 1'b0; ht = 1'b0; hp = 1'b0;
    if (m_armed) begin
      hx = ext_edge_rise ? (!p_pin && ext_pin) : (p_pin && !ext_pin);
      ht = (p_tmr == 8'hFF) && (tmr_count == 8'h00);
      hp = (p_port != port_hi);
    end
    wc  = reg_we && !reg_sel;
    wm  = reg_we && reg_sel;
    nxt = wc ? reg_wdata : m_ctrl;
    if (!wc && !irq_ack && !irq_ret) nxt[7] = m_ctrl[7];
    if (hx) nxt[1] = 1'b1;
    if (ht) nxt[2] = 1'b1;
    if (hp) nxt[0] = 1'b1;
    if (irq_ack)      nxt[7] = 1'b0;
    else if (irq_ret) nxt[7] = 1'b1;
    m_ctrl  = nxt;
    m_nv    = nvm_wr_done || (wm ? reg_wdata[4] : m_nv);
    p_pin   = ext_pin;
    p_tmr   = tmr_count;
    p_port  = port_hi;
    m_armed = 1'b1;
    @(negedge clk);
    check_all();
    reg_we      = 1'b0;
    irq_ack     = 1'b0;
    irq_ret     = 1'b0;
    nvm_wr_done = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = data;
    tick();
  endtask

  initial begin
    int seed_v;
    int r;
    seed_v = $urandom(32'h5EED_1234);
    m_ctrl = 8'h00; m_nv = 1'b0; m_armed = 1'b0;
    p_pin = 1'b0; p_tmr = 8'h00; p_port = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ctrl after reset", 32'(reg_rdata), 32'h00);
    chk("R1 irq_req after reset", 32'(irq_req), 32'h0);
    chk("R1 wake_req after reset", 32'(wake_req), 32'h0);
    check_all();

    // R12: first edge only samples
    ext_edge_rise = 1'b1; ext_pin = 1'b1; port_hi = 4'hA;
    tick();
    chk("R12 no event on first edge", 32'(reg_rdata), 32'h00);

    // R2 / R6: falling edge with every enable off
    ext_edge_rise = 1'b0; ext_pin = 1'b0;
    tick();
    chk("R2/R6 falling edge sets pin flag", 32'(reg_rdata[1]), 32'h1);
    wr(1'b0, 8'h00);
    ext_edge_rise = 1'b1; ext_pin = 1'b1;
    tick();
    chk("R2 rising edge sets pin flag", 32'(reg_rdata[1]), 32'h1);
    wr(1'b0, 8'h00);
    ext_pin = 1'b0;
    tick();
    chk("R2 opposite edge ignored", 32'(reg_rdata), 32'h00);

    // R3 timer rollover
    tmr_count = 8'hFF;
    tick();
    chk("R3 no flag before rollover", 32'(reg_rdata[2]), 32'h0);
    tmr_count = 8'h00;
    tick();
    chk("R3 rollover sets timer flag", 32'(reg_rdata[2]), 32'h1);
    wr(1'b0, 8'h00);
    tmr_count = 8'h7F; tick();
    tmr_count = 8'h80; tick();
    chk("R3 other transition ignored", 32'(reg_rdata), 32'h00);

    // R4 port change
    port_hi = 4'h2;
    tick();
    chk("R4 port change sets flag", 32'(reg_rdata[0]), 32'h1);
    wr(1'b0, 8'h00);
    tick();
    chk("R4 steady port no flag", 32'(reg_rdata), 32'h00);

    // R5 / R13 memory-control register
    nvm_wr_done = 1'b1; reg_sel = 1'b1;
    tick();
    chk("R5 write-done flag at bit 4", 32'(reg_rdata), 32'h10);
    wr(1'b1, 8'hEF);
    chk("R13 memctl write clears bit 4 only", 32'(reg_rdata), 32'h00);
    wr(1'b1, 8'hFF);
    chk("R13 memctl other bits read 0", 32'(reg_rdata), 32'h10);
    wr(1'b1, 8'h00);
    reg_sel = 1'b0;

    // R7 request
    ext_pin = 1'b1;
    tick();
    wr(1'b0, 8'h92);
    chk("R7 irq_req with gen and pin", 32'(irq_req), 32'h1);
    chk("R7 vector value", 32'(irq_vector), 32'h004);

    // R8 acknowledge
    irq_ack = 1'b1;
    tick();
    chk("R8 ack clears global enable", 32'(reg_rdata[7]), 32'h0);
    chk("R8 no request after ack", 32'(irq_req), 32'h0);

    // R9 return re-requests
    irq_ret = 1'b1;
    tick();
    chk("R9 return sets global enable", 32'(reg_rdata[7]), 32'h1);
    chk("R9 pending flag re-requests", 32'(irq_req), 32'h1);

    // R8 collisions
    irq_ack = 1'b1; irq_ret = 1'b1;
    tick();
    chk("R8 ack beats return", 32'(reg_rdata[7]), 32'h0);
    irq_ack = 1'b1;
    wr(1'b0, 8'h92);
    chk("R8 ack beats write", 32'(reg_rdata[7]), 32'h0);

    // R10 set beats clear
    ext_edge_rise = 1'b0; ext_pin = 1'b0;
    wr(1'b0, 8'h00);
    chk("R10 set wins over clear", 32'(reg_rdata), 32'h02);

    // R11 wake without global enable
    wr(1'b0, 8'h12);
    core_sleep = 1'b1;
    tick();
    chk("R11 wake with gen off", 32'(wake_req), 32'h1);
    chk("R11 no request with gen off", 32'(irq_req), 32'h0);
    core_sleep = 1'b0;
    tick();
    chk("R11 no wake when awake", 32'(wake_req), 32'h0);
    wr(1'b0, 8'h10);
    core_sleep = 1'b1;
    tick();
    chk("R11 no wake without flag", 32'(wake_req), 32'h0);
    core_sleep = 1'b0;

    // constrained random phase
    for (int i = 0; i < RAND_CYCLES; i++) begin
      r = $urandom;
      if (r[2:0] == 3'd0) ext_pin = ~ext_pin;
      if (r[27:25] == 3'd0) ext_edge_rise = ~ext_edge_rise;
      tmr_count   = (r[5:3] != 3'd0) ? tmr_count + 8'd1 : 8'($urandom);
      if (r[8:6] == 3'd0) port_hi = 4'($urandom);
      nvm_wr_done = (r[12:9] == 4'd0);
      reg_we      = (r[15:13] == 3'd0);
      reg_sel     = r[16];
      reg_wdata   = 8'($urandom);
      irq_ack     = (r[20:18] == 3'd0);
      irq_ret     = (r[23:21] == 3'd0);
      core_sleep  = r[24];
      tick();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule